// File: doc/BRIEF.md
# Skewed Envelope Segment Generator

This block generates a single-channel, unipolar digital envelope. The envelope is one linear rise followed by one linear fall. Together the two segments fill a total period given in clock cycles. An 8-bit skew value moves the boundary between rise and fall without changing the total length. A start command launches the envelope, and the present period and skew are captured at that moment. If the sustain-hold input is asserted when the rise finishes, the level stays at full scale until hold is released.

Three gates follow the segment timing. The end-of-rise gate marks that a rise has completed. The end-of-fall gate marks that a fall has completed. The half-rise gate is timed by elapsed cycles within each segment, not by comparing the level against a threshold.

A start that arrives while an envelope is running begins a new rise from the present level, so the output does not jump. A restart command instead begins a new rise from zero. A busy flag reports whether a rise, sustain or fall is in progress.

Top module: `env_skew_gen`

## Requirements
- R1: The period and skew are captured on the clock edge where start or restart is seen. The effective period P is the period input, or 2 if that input is below 2. The rise length is floor(P*skew/256), raised to 1 if it comes out as 0. The fall length F is P minus the rise length.
- R2: Count k from 0 at the first sample after the start edge. For k below the rise length L, the level is floor(4095*(k+1)/L) when the envelope starts from zero, so the last rise cycle shows 4095.
- R3: Without hold, fall cycle j (j = k - L) shows level floor(4095*(F-1-j)/F), so the last fall cycle shows 0. From cycle k = P on, the block is idle with level 0 and busy low.
- R4: The end-of-rise gate goes low on the edge where a rise begins. It goes high on the edge where a rise completes, and it stays high through sustain, fall and idle until the next rise.
- R5: The end-of-fall gate goes low on the edge where a fall begins and goes high on the edge where a fall completes. It is unchanged by the start of a rise.
- R6: The half-rise gate is high during rise cycles with k >= floor(L/2), during sustain, and during fall cycles with j < floor(F/2). It is low in idle and in all other cycles.
- R7: If hold is high on the edge of the last rise cycle, the level stays at 4095 with busy, end-of-rise and half-rise high for as long as hold is high. The cycle after the edge that sees hold low is fall cycle j = 0.
- R8: A start seen during rise, sustain or fall begins a new rise with counting from k = 0. In that rise the level is the larger of the level present at the start edge and floor(4095*(k+1)/L).
- R9: A restart begins a new rise whose level is floor(4095*(k+1)/L), ignoring the present level. Restart takes priority over start in the same cycle.
- R10: After synchronous reset the level is 0, end-of-fall is high, end-of-rise, half-rise and busy are low.
- R11: Busy is high in every rise, sustain and fall cycle and low in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Total envelope length in cycles |
| skew_i | input | 8 | Rise share of the period, in 1/256 units |
| start_i | input | 1 | Begin a rise from the present level |
| hold_i | input | 1 | Sustain at full scale after the rise |
| restart_i | input | 1 | Begin a rise from zero |
| level_o | output | 12 | Envelope level |
| eor_o | output | 1 | End-of-rise gate |
| eof_o | output | 1 | End-of-fall gate |
| half_o | output | 1 | Half-rise gate |
| busy_o | output | 1 | Envelope in progress |

## Verification
Start and restart are registered on one edge, and every output is then a combinational function of the registered state. The first rise value is therefore visible in the sample that follows the command edge (k = 0), and each later cycle advances k by one. The bench drives and samples on the falling clock edge. It steps exactly one cycle per expected value, so each table vector is compared against the formulas of R2, R3 and R6 at every k up to two cycles past P. Hold release, mid-envelope start and restart are each checked on the first sample after the edge that sees them.

// File: rtl/env_skew_pkg.sv
package env_skew_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_HOLD = 2'd2,
        ST_FALL = 2'd3
    } env_state_e;

    localparam int DEF_PERIOD_W = 16;
    localparam int DEF_SKEW_W   = 8;
    localparam int DEF_LEVEL_W  = 12;

endpackage

// File: rtl/env_seg_split.sv
module env_seg_split #(
    parameter int PERIOD_W = env_skew_pkg::DEF_PERIOD_W,
    parameter int SKEW_W   = env_skew_pkg::DEF_SKEW_W
) (
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [SKEW_W-1:0]   skew_i,
    output logic [PERIOD_W-1:0] rise_len_o,
    output logic [PERIOD_W-1:0] fall_len_o
);
    localparam int PROD_W = PERIOD_W + SKEW_W;

    logic [PERIOD_W-1:0] p_eff;
    logic [PROD_W-1:0]   prod;
    logic [PERIOD_W-1:0] r_raw;

    always_comb begin
        p_eff      = (period_i < PERIOD_W'(2)) ? PERIOD_W'(2) : period_i;
        prod       = PROD_W'(p_eff) * PROD_W'(skew_i);
        r_raw      = PERIOD_W'(prod >> SKEW_W);
        rise_len_o = (r_raw == '0) ? PERIOD_W'(1) : r_raw;
        fall_len_o = p_eff - rise_len_o;
    end

endmodule

// File: rtl/env_ramp.sv
module env_ramp
    import env_skew_pkg::*;
#(
    parameter int PERIOD_W = DEF_PERIOD_W,
    parameter int LEVEL_W  = DEF_LEVEL_W
) (
    input  env_state_e          state_i,
    input  logic [PERIOD_W-1:0] cnt_i,
    input  logic [PERIOD_W-1:0] rise_len_i,
    input  logic [PERIOD_W-1:0] fall_len_i,
    input  logic [LEVEL_W-1:0]  base_i,
    output logic [LEVEL_W-1:0]  level_o
);
    localparam int MUL_W = PERIOD_W + LEVEL_W;
    localparam logic [LEVEL_W-1:0] MAXV = '1;

    logic [PERIOD_W-1:0] num;
    logic [PERIOD_W-1:0] den;
    logic [LEVEL_W-1:0]  ramp;

    always_comb begin
        if (state_i == ST_FALL) begin
            num = fall_len_i - cnt_i - PERIOD_W'(1);
            den = fall_len_i;
        end else begin
            num = cnt_i + PERIOD_W'(1);
            den = rise_len_i;
        end
        if (den == '0) den = PERIOD_W'(1);
        ramp = LEVEL_W'((MUL_W'(num) * MUL_W'(MAXV)) / MUL_W'(den));

        unique case (state_i)
            ST_RISE: level_o = (base_i > ramp) ? base_i : ramp;
            ST_HOLD: level_o = MAXV;
            ST_FALL: level_o = ramp;
            default: level_o = '0;
        endcase
    end

endmodule

// File: rtl/env_seq.sv
module env_seq
    import env_skew_pkg::*;
#(
    parameter int PERIOD_W = DEF_PERIOD_W,
    parameter int LEVEL_W  = DEF_LEVEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                restart_i,
    input  logic                hold_i,
    input  logic [PERIOD_W-1:0] rise_in_i,
    input  logic [PERIOD_W-1:0] fall_in_i,
    input  logic [LEVEL_W-1:0]  level_i,
    output env_state_e          state_o,
    output logic [PERIOD_W-1:0] cnt_o,
    output logic [PERIOD_W-1:0] rise_len_o,
    output logic [PERIOD_W-1:0] fall_len_o,
    output logic [LEVEL_W-1:0]  base_o,
    output logic                eor_o,
    output logic                eof_o,
    output logic                half_o
);
    env_state_e          st_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] rlen_q;
    logic [PERIOD_W-1:0] flen_q;
    logic [LEVEL_W-1:0]  base_q;
    logic                eor_q;
    logic                eof_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            rlen_q <= PERIOD_W'(1);
            flen_q <= PERIOD_W'(1);
            base_q <= '0;
            eor_q  <= 1'b0;
            eof_q  <= 1'b1;
        end else if (restart_i || start_i) begin
            st_q   <= ST_RISE;
            cnt_q  <= '0;
            rlen_q <= rise_in_i;
            flen_q <= fall_in_i;
            base_q <= restart_i ? '0 : level_i;
            eor_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_RISE: begin
                    if (cnt_q == rlen_q - PERIOD_W'(1)) begin
                        eor_q <= 1'b1;
                        cnt_q <= '0;
                        if (hold_i) begin
                            st_q <= ST_HOLD;
                        end else begin
                            st_q  <= ST_FALL;
                            eof_q <= 1'b0;
                        end
                    end else begin
                        cnt_q <= cnt_q + PERIOD_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (!hold_i) begin
                        st_q  <= ST_FALL;
                        cnt_q <= '0;
                        eof_q <= 1'b0;
                    end
                end
                ST_FALL: begin
                    if (cnt_q == flen_q - PERIOD_W'(1)) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                        eof_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + PERIOD_W'(1);
                    end
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            ST_RISE: half_o = (cnt_q >= (rlen_q >> 1));
            ST_HOLD: half_o = 1'b1;
            ST_FALL: half_o = (cnt_q < (flen_q >> 1));
            default: half_o = 1'b0;
        endcase
    end

    assign state_o    = st_q;
    assign cnt_o      = cnt_q;
    assign rise_len_o = rlen_q;
    assign fall_len_o = flen_q;
    assign base_o     = base_q;
    assign eor_o      = eor_q;
    assign eof_o      = eof_q;

endmodule

// File: rtl/env_skew_gen.sv
module env_skew_gen
    import env_skew_pkg::*;
#(
    parameter int PERIOD_W = DEF_PERIOD_W,
    parameter int SKEW_W   = DEF_SKEW_W,
    parameter int LEVEL_W  = DEF_LEVEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [SKEW_W-1:0]   skew_i,
    input  logic                start_i,
    input  logic                hold_i,
    input  logic                restart_i,
    output logic [LEVEL_W-1:0]  level_o,
    output logic                eor_o,
    output logic                eof_o,
    output logic                half_o,
    output logic                busy_o
);
    logic [PERIOD_W-1:0] rise_new, fall_new;
    logic [PERIOD_W-1:0] rise_len, fall_len, cnt;
    logic [LEVEL_W-1:0]  base;
    env_state_e          state;

    env_seg_split #(.PERIOD_W(PERIOD_W), .SKEW_W(SKEW_W)) i_split (
        .period_i   (period_i),
        .skew_i     (skew_i),
        .rise_len_o (rise_new),
        .fall_len_o (fall_new)
    );

    env_seq #(.PERIOD_W(PERIOD_W), .LEVEL_W(LEVEL_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .restart_i  (restart_i),
        .hold_i     (hold_i),
        .rise_in_i  (rise_new),
        .fall_in_i  (fall_new),
        .level_i    (level_o),
        .state_o    (state),
        .cnt_o      (cnt),
        .rise_len_o (rise_len),
        .fall_len_o (fall_len),
        .base_o     (base),
        .eor_o      (eor_o),
        .eof_o      (eof_o),
        .half_o     (half_o)
    );

    env_ramp #(.PERIOD_W(PERIOD_W), .LEVEL_W(LEVEL_W)) i_ramp (
        .state_i    (state),
        .cnt_i      (cnt),
        .rise_len_i (rise_len),
        .fall_len_i (fall_len),
        .base_i     (base),
        .level_o    (level_o)
    );

    assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/env_skew_gen_chk.sv
module env_skew_gen_chk #(
    parameter int LEVEL_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               restart_i,
    input logic               hold_i,
    input logic [LEVEL_W-1:0] level_o,
    input logic               eor_o,
    input logic               eof_o,
    input logic               half_o,
    input logic               busy_o
);
    localparam logic [LEVEL_W-1:0] MAXV = '1;

    a_r4_eor_low_after_begin: assert property (@(posedge clk) disable iff (rst)
        (start_i || restart_i) |=> !eor_o);

    a_r3_idle_level_zero: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (level_o == '0));

    a_r6_half_low_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !half_o);

    a_r5_eof_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> eof_o);

    a_r7_hold_keeps_max: assert property (@(posedge clk) disable iff (rst)
        (busy_o && eor_o && hold_i && level_o == MAXV && !start_i && !restart_i)
        |=> (busy_o && level_o == MAXV));

    a_r2_rise_monotonic: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !eor_o && !start_i && !restart_i)
        |=> (eor_o || level_o >= $past(level_o)));

endmodule

bind env_skew_gen env_skew_gen_chk #(.LEVEL_W(LEVEL_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .restart_i (restart_i),
    .hold_i    (hold_i),
    .level_o   (level_o),
    .eor_o     (eor_o),
    .eof_o     (eof_o),
    .half_o    (half_o),
    .busy_o    (busy_o)
);

// File: tb/test_env_skew_gen.sv
module test_env_skew_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {period[39:24], skew[23:16], expected rise length[15:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'd10,  8'd128, 16'd5},
        {16'd10,  8'd0,   16'd1},
        {16'd10,  8'd255, 16'd9},
        {16'd7,   8'd64,  16'd1},
        {16'd20,  8'd200, 16'd15},
        {16'd1,   8'd0,   16'd1},
        {16'd100, 8'd77,  16'd30},
        {16'd3,   8'd255, 16'd2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] period_i;
    logic [7:0]  skew_i;
    logic        start_i, hold_i, restart_i;
    logic [11:0] level_o;
    logic        eor_o, eof_o, half_o, busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    env_skew_gen i_env_skew_gen (
        .clk(clk), .rst(rst), .period_i(period_i), .skew_i(skew_i),
        .start_i(start_i), .hold_i(hold_i), .restart_i(restart_i),
        .level_o(level_o), .eor_o(eor_o), .eof_o(eof_o),
        .half_o(half_o), .busy_o(busy_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive a one-cycle command; returns at the k = 0 sample point
    task automatic fire(input bit use_restart, input bit use_start);
        restart_i = use_restart;
        start_i   = use_start;
        @(negedge clk);
        restart_i = 1'b0;
        start_i   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; period_i = 16'd10; skew_i = 8'd128;
        start_i = 1'b0; hold_i = 1'b0; restart_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10", "level", int'(level_o), 0);
        chk("R10", "eof", int'(eof_o), 1);
        chk("R10", "eor", int'(eor_o), 0);
        chk("R10", "half", int'(half_o), 0);
        chk("R10", "busy", int'(busy_o), 0);
        @(negedge clk);

        // vector walk: R1 split, R2 rise, R3 fall/idle, R4 R5 R6 gates, R11 busy
        for (int v = 0; v < NVEC; v++) begin
            int p, rl, fl;
            p  = int'(VEC[v][39:24]);
            if (p < 2) p = 2;
            rl = int'(VEC[v][15:0]);
            fl = p - rl;
            period_i = VEC[v][39:24];
            skew_i   = VEC[v][23:16];
            fire(1'b0, 1'b1);
            for (int k = 0; k < p + 2; k++) begin
                int e_lvl, e_eor, e_eof, e_half, e_busy;
                if (k < rl) begin
                    e_lvl = 4095 * (k + 1) / rl;
                    e_eor = 0; e_eof = 1; e_busy = 1;
                    e_half = (k >= rl / 2) ? 1 : 0;
                end else if (k < p) begin
                    e_lvl = 4095 * (fl - 1 - (k - rl)) / fl;
                    e_eor = 1; e_eof = 0; e_busy = 1;
                    e_half = ((k - rl) < fl / 2) ? 1 : 0;
                end else begin
                    e_lvl = 0; e_eor = 1; e_eof = 1; e_busy = 0; e_half = 0;
                end
                chk((k < rl) ? "R1/R2" : "R1/R3", "level", int'(level_o), e_lvl);
                chk("R4", "eor", int'(eor_o), e_eor);
                chk("R5", "eof", int'(eof_o), e_eof);
                chk("R6", "half", int'(half_o), e_half);
                chk("R11", "busy", int'(busy_o), e_busy);
                @(negedge clk);
            end
        end

        // R7 hold: period 10, skew 128 -> rise 5, fall 5
        period_i = 16'd10; skew_i = 8'd128;
        hold_i = 1'b1;
        fire(1'b0, 1'b1);
        repeat (10) @(negedge clk);
        chk("R7", "sustain level", int'(level_o), 4095);
        chk("R7", "sustain busy", int'(busy_o), 1);
        chk("R7", "sustain eor", int'(eor_o), 1);
        chk("R7", "sustain half", int'(half_o), 1);
        hold_i = 1'b0;
        @(negedge clk);
        chk("R7", "first fall level", int'(level_o), 3276);
        chk("R5", "eof after hold release", int'(eof_o), 0);
        repeat (6) @(negedge clk);
        chk("R3", "idle after hold", int'(busy_o), 0);

        // R8 start during fall: period 20, skew 128 -> rise 10, fall 10
        period_i = 16'd20; skew_i = 8'd128;
        fire(1'b0, 1'b1);
        repeat (12) @(negedge clk);
        chk("R3", "fall j=2 level", int'(level_o), 2866);
        fire(1'b0, 1'b1);
        chk("R8", "level kept at start", int'(level_o), 2866);
        chk("R8", "eor low in new rise", int'(eor_o), 0);
        chk("R5", "eof unchanged by rise", int'(eof_o), 0);
        repeat (7) @(negedge clk);
        chk("R8", "ramp overtakes base", int'(level_o), 3276);

        // R9 restart with start in the same cycle: from zero, new period 10 -> rise 5
        period_i = 16'd10;
        fire(1'b1, 1'b1);
        chk("R9", "restart level", int'(level_o), 819);
        chk("R9", "restart eor", int'(eor_o), 0);
        repeat (10) @(negedge clk);
        chk("R3", "idle level", int'(level_o), 0);
        chk("R5", "eof after finish", int'(eof_o), 1);
        chk("R11", "busy idle", int'(busy_o), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule